// File: doc/BRIEF.md
# ISA Command Cycle Sequencer with Wait-State Control

This block runs a single ISA bus command on the local side of a bridge. A command can be a memory or I/O access, a read or a write, and 8 or 16 bits wide. The block drives one of four active-low command strobes and counts the data-valid periods that elapse while the strobe is held. It ends the command either when the default wait-state budget for that access type runs out, or earlier when the peripheral pulls its active-low early-end line (`early_n`) at a point where sampling is allowed.

The points at which `early_n` is sampled depend on a policy fixed when the request is accepted. The compliant policy follows ISA rules for each access type. The fast policy samples from the first data-valid period for every access. An optional one-clock delay of `early_n` forces at least one wait state on every access.

Requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low for the whole of a running command. A request raised while `req_ready` is low is not queued: it has no effect unless it is still high once `req_ready` returns. The requester must therefore hold `req_valid` and its attributes until the handshake completes.

Top module: `isa_wait_ctrl`

## Requirements
- R1: The attributes `{req_io, req_wr}` select the strobe: 00 gives `strb_mem_rd_n`, 01 gives `strb_mem_wr_n`, 10 gives `strb_io_rd_n` and 11 gives `strb_io_wr_n`. During a command exactly that strobe is low. At all other times every strobe is high.
- R2: If `early_n` is never low (it is active low), an 8-bit access takes 4 wait states and a 16-bit access takes 1 wait state.
- R3: Under the compliant policy (`fast_mode`=0) with no delay, a 16-bit memory access samples `early_n` in the first data-valid period. If it is sampled low there, the access ends with 0 wait states.
- R4: Under the compliant policy with no delay, a 16-bit I/O access ignores `early_n` and always takes exactly 1 wait state.
- R5: Under the compliant policy with no delay, an 8-bit access samples `early_n` in the second data-valid period and in every later one. It never samples it in the first, so it takes at least 1 wait state.
- R6: Under the fast policy (`fast_mode`=1) with no delay, every access type samples `early_n` in every data-valid period from the first. A low sample in the first period gives 0 wait states.
- R7: With `dly_en`=1, the value of `early_n` that is used is the value from one clock earlier. This delayed value is treated as high in the first data-valid period, so every access has at least 1 wait state.
- R8: A data-valid period lasts 2 clocks, and the sample is the value present at the end of its first clock. The strobe falls in the clock after acceptance and stays low for 2×(W+1) clocks, where W is the number of wait states.
- R9: `busy` is high exactly while a strobe is low. `done` is high for one clock, in the last clock the strobe is low.
- R10: `req_ready` is high only while idle. A request raised while `busy` is high starts no command and does not disturb the running one.
- R11: After each command, all strobes are high for at least one clock before the next command's strobe falls.
- R12: `fast_mode`, `dly_en`, `req_io`, `req_wr` and `req_w16` are captured at acceptance. Changing them during a command does not affect its strobe or its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle; the request is taken at this edge |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_w16 | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| fast_mode | input | 1 | 1 = sample early-end from the first period for all accesses |
| dly_en | input | 1 | 1 = use early-end delayed by one clock |
| early_n | input | 1 | Peripheral early-end request, active low |
| strb_mem_rd_n | output | 1 | Memory read strobe, active low |
| strb_mem_wr_n | output | 1 | Memory write strobe, active low |
| strb_io_rd_n | output | 1 | I/O read strobe, active low |
| strb_io_wr_n | output | 1 | I/O write strobe, active low |
| busy | output | 1 | Command in progress |
| done | output | 1 | Last clock of the strobe |

## Verification
Two events can fall on the same clock. One is the final clock of a command, when `done` is high. The other is a new request that is already waiting, so acceptance could coincide with the strobe release. The bench provokes this by holding `req_valid` high across two commands. It judges the result by requiring exactly one clock with all strobes high between the two strobe-low runs. A second collision is between the mid-period sample and changes to the policy inputs. Every command in the sweep inverts `fast_mode`, `dly_en` and the attributes right after acceptance, and its length is still compared with the value worked out from the original settings.

// File: rtl/isa_wait_pkg.sv
package isa_wait_pkg;

  // Strobe index; the encoding equals {io, wr}
  typedef enum logic [1:0] {
    CMD_MEM_RD = 2'd0,
    CMD_MEM_WR = 2'd1,
    CMD_IO_RD  = 2'd2,
    CMD_IO_WR  = 2'd3
  } isa_cmd_e;

  localparam int NUM_STROBES = 4;

  // Request attributes latched at acceptance
  typedef struct packed {
    logic io;
    logic wr;
    logic w16;
    logic fast;
    logic dly;
  } isa_req_t;

endpackage

// File: rtl/isa_early_delay.sv
// Optional delay line for the early-end input. The stages are forced to
// "not asserted" when a command is accepted, so a delayed view never
// carries a value from before the command.
module isa_early_delay #(
  parameter int DLY_CLKS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic dly_en,
  input  logic early_n_in,
  output logic early_n_out
);

  logic [DLY_CLKS:0] chain;

  assign chain[0] = early_n_in;

  for (genvar g = 0; g < DLY_CLKS; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     chain[g+1] <= 1'b1;
      else if (clear) chain[g+1] <= 1'b1;
      else            chain[g+1] <= chain[g];
    end
  end

  assign early_n_out = dly_en ? chain[DLY_CLKS] : early_n_in;

endmodule

// File: rtl/isa_sample_gate.sv
// Decides whether the early-end line may be sampled in a given period.
module isa_sample_gate #(
  parameter int CW            = 3,
  parameter int FIRST_8BIT_PER = 1
) (
  input  logic          fast,
  input  logic          io,
  input  logic          w16,
  input  logic [CW-1:0] per,
  output logic          en
);

  always_comb begin
    if (fast)     en = 1'b1;                       // every period, every type
    else if (w16) en = !io;                        // 16-bit memory only
    else          en = (per >= CW'(FIRST_8BIT_PER)); // 8-bit: from later period
  end

endmodule

// File: rtl/isa_strobe_decode.sv
// One-hot active-low strobe decode.
module isa_strobe_decode
  import isa_wait_pkg::*;
(
  input  logic                   active,
  input  isa_cmd_e               cmd,
  output logic [NUM_STROBES-1:0] strb_n
);

  for (genvar i = 0; i < NUM_STROBES; i++) begin : g_strb
    assign strb_n[i] = !(active && (cmd == isa_cmd_e'(i)));
  end

endmodule

// File: rtl/isa_wait_ctrl.sv
// ISA command sequencer with configurable early-end sampling.
// PER_CLKS must be 2 or more: the sample and the period end are on
// different edges.
module isa_wait_ctrl
  import isa_wait_pkg::*;
#(
  parameter int WS_8BIT  = 4,
  parameter int WS_16BIT = 1,
  parameter int PER_CLKS = 2,
  parameter int DLY_CLKS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic req_ready,
  input  logic req_io,
  input  logic req_wr,
  input  logic req_w16,
  input  logic fast_mode,
  input  logic dly_en,
  input  logic early_n,
  output logic strb_mem_rd_n,
  output logic strb_mem_wr_n,
  output logic strb_io_rd_n,
  output logic strb_io_wr_n,
  output logic busy,
  output logic done
);

  localparam int MAX_WS = (WS_8BIT > WS_16BIT) ? WS_8BIT : WS_16BIT;
  localparam int CW     = (MAX_WS > 0) ? $clog2(MAX_WS + 1) : 1;
  localparam int PW     = (PER_CLKS > 1) ? $clog2(PER_CLKS) : 1;

  logic          busy_q;
  isa_req_t      cfg_q;
  logic [PW-1:0] ph_q;
  logic [CW-1:0] per_q;
  logic          hit_q;

  logic          accept;
  logic          ph_samp;
  logic          ph_last;
  logic [CW-1:0] lim;
  logic          fin;
  logic          samp_en;
  logic          early_use_n;
  isa_cmd_e      cmd;
  logic [NUM_STROBES-1:0] strb_n;

  assign accept  = req_valid && !busy_q;
  assign ph_samp = (ph_q == '0);
  assign ph_last = (ph_q == PW'(PER_CLKS - 1));
  assign lim     = cfg_q.w16 ? CW'(WS_16BIT) : CW'(WS_8BIT);
  assign fin     = hit_q || (per_q == lim);
  assign cmd     = isa_cmd_e'({cfg_q.io, cfg_q.wr});

  isa_early_delay #(.DLY_CLKS(DLY_CLKS)) u_dly (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (accept),
    .dly_en      (cfg_q.dly),
    .early_n_in  (early_n),
    .early_n_out (early_use_n)
  );

  isa_sample_gate #(.CW(CW), .FIRST_8BIT_PER(1)) u_gate (
    .fast (cfg_q.fast),
    .io   (cfg_q.io),
    .w16  (cfg_q.w16),
    .per  (per_q),
    .en   (samp_en)
  );

  isa_strobe_decode u_dec (
    .active (busy_q),
    .cmd    (cmd),
    .strb_n (strb_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cfg_q  <= '0;
      ph_q   <= '0;
      per_q  <= '0;
      hit_q  <= 1'b0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cfg_q  <= '{io: req_io, wr: req_wr, w16: req_w16,
                  fast: fast_mode, dly: dly_en};
      ph_q   <= '0;
      per_q  <= '0;
      hit_q  <= 1'b0;
    end else if (busy_q) begin
      // mid-period sample at the end of the first clock
      if (ph_samp && samp_en && !early_use_n)
        hit_q <= 1'b1;
      if (ph_last) begin
        ph_q <= '0;
        if (fin) busy_q <= 1'b0;
        else     per_q  <= per_q + 1'b1;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  assign req_ready     = !busy_q;
  assign busy          = busy_q;
  assign done          = busy_q && ph_last && fin;
  assign strb_mem_rd_n = strb_n[CMD_MEM_RD];
  assign strb_mem_wr_n = strb_n[CMD_MEM_WR];
  assign strb_io_rd_n  = strb_n[CMD_IO_RD];
  assign strb_io_wr_n  = strb_n[CMD_IO_WR];

endmodule

// File: rtl/isa_wait_ctrl_chk.sv
module isa_wait_ctrl_chk #(
  parameter int WS_8BIT  = 4,
  parameter int WS_16BIT = 1,
  parameter int PER_CLKS = 2
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic strb_mem_rd_n,
  input logic strb_mem_wr_n,
  input logic strb_io_rd_n,
  input logic strb_io_wr_n,
  input logic busy,
  input logic done
);

  localparam int MAX_WS  = (WS_8BIT > WS_16BIT) ? WS_8BIT : WS_16BIT;
  localparam int MAX_LEN = PER_CLKS * (MAX_WS + 1);

  logic [3:0]  low_v;
  logic [15:0] len_q;

  assign low_v = ~{strb_io_wr_n, strb_io_rd_n, strb_mem_wr_n, strb_mem_rd_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    len_q <= '0;
    else if (busy) len_q <= len_q + 16'd1;
    else           len_q <= '0;
  end

  // R1
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(low_v) <= 1);

  // R9
  busy_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (low_v != 4'd0));

  // R11
  done_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (low_v == 4'd0) && !busy);

  // R10
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  // R12
  strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(low_v));

  // R2
  max_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (len_q < 16'(MAX_LEN)));

  // R8
  whole_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (((len_q + 16'd1) % 16'(PER_CLKS)) == 16'd0));

endmodule

bind isa_wait_ctrl isa_wait_ctrl_chk #(
  .WS_8BIT  (WS_8BIT),
  .WS_16BIT (WS_16BIT),
  .PER_CLKS (PER_CLKS)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .strb_mem_rd_n (strb_mem_rd_n),
  .strb_mem_wr_n (strb_mem_wr_n),
  .strb_io_rd_n  (strb_io_rd_n),
  .strb_io_wr_n  (strb_io_wr_n),
  .busy          (busy),
  .done          (done)
);

// File: tb/test_isa_wait_ctrl.sv
module test_isa_wait_ctrl;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, req_valid, req_ready, req_io, req_wr, req_w16;
  logic fast_mode, dly_en, early_n;
  logic strb_mem_rd_n, strb_mem_wr_n, strb_io_rd_n, strb_io_wr_n, busy, done;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit finished = 0;

  always @(posedge clk) cyc++;

  isa_wait_ctrl i_isa_wait_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_io(req_io), .req_wr(req_wr), .req_w16(req_w16),
    .fast_mode(fast_mode), .dly_en(dly_en), .early_n(early_n),
    .strb_mem_rd_n(strb_mem_rd_n), .strb_mem_wr_n(strb_mem_wr_n),
    .strb_io_rd_n(strb_io_rd_n), .strb_io_wr_n(strb_io_wr_n),
    .busy(busy), .done(done)
  );

  function automatic logic [3:0] strb();
    return {strb_io_wr_n, strb_io_rd_n, strb_mem_wr_n, strb_mem_rd_n};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Wait states from the requirements; early_n goes low from strobe clock t on
  function automatic int exp_ws(bit io, bit w16, bit fast, bit dly, int t);
    int lim = w16 ? 1 : 4;
    for (int p = 0; p < lim; p++) begin
      bit en  = fast ? 1'b1 : (w16 ? !io : (p >= 1));
      bit hit = dly ? ((p >= 1) && (2*p - 1 >= t)) : (2*p >= t);
      if (en && hit) return p;
    end
    return lim;
  endfunction

  task automatic run_cycle(bit io, bit wr, bit w16, bit fast, bit dly, int t, bit poke);
    int w, low, donej;
    logic [3:0] expv;
    string tag;
    w     = exp_ws(io, w16, fast, dly, t);
    expv  = ~(4'b0001 << {io, wr});
    if (t > 50)        tag = "R2";
    else if (dly)      tag = "R7";
    else if (fast)     tag = "R6";
    else if (w16 && io) tag = "R4";
    else if (w16)      tag = "R3";
    else               tag = "R5";
    @(negedge clk);
    req_io = io; req_wr = wr; req_w16 = w16; fast_mode = fast; dly_en = dly;
    early_n = 1'b1; req_valid = 1'b1;
    chk(req_ready === 1'b1, "R10 ready when idle", int'(req_ready), 1);
    @(posedge clk);
    low = 0; donej = -1;
    for (int j = 0; j < 40; j++) begin
      @(negedge clk);
      if (j == 0) begin
        req_valid = 1'b0;
        // R12: disturb every latched input
        fast_mode = !fast; dly_en = !dly; req_io = !io; req_wr = !wr; req_w16 = !w16;
      end
      if (poke) req_valid = (j == 1);
      if (&strb()) break;
      low++;
      chk(strb() === expv, "R1 R12 strobe select", int'(strb()), int'(expv));
      chk(busy === 1'b1, "R9 busy during strobe", int'(busy), 1);
      if (done) donej = j;
      early_n = !(j >= t);
    end
    req_valid = 1'b0;
    chk(low == 2*(w+1), {tag, " R8 R12 strobe length"}, low, 2*(w+1));
    chk(donej == 2*w+1, "R9 done position", donej, 2*w+1);
    chk(busy === 1'b0 && done === 1'b0, "R11 idle after command", int'(busy), 0);
    repeat (2) begin
      @(negedge clk);
      chk((&strb()) && !busy, poke ? "R10 request while busy ignored" : "R11 idle strobes",
          int'(strb()), 15);
    end
  endtask

  // R11: request held across two commands
  task automatic back_to_back();
    bit exp_low;
    @(negedge clk);
    req_io = 1'b0; req_wr = 1'b1; req_w16 = 1'b1; fast_mode = 1'b0; dly_en = 1'b0;
    early_n = 1'b1; req_valid = 1'b1;
    @(posedge clk);
    for (int j = 0; j < 12; j++) begin
      @(negedge clk);
      exp_low = (j <= 3) || (j >= 5 && j <= 8);
      chk((strb() != 4'hF) == exp_low, "R11 back-to-back gap", int'(strb() != 4'hF), int'(exp_low));
      if (j == 5) req_valid = 1'b0;
    end
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_io = 1'b0; req_wr = 1'b0; req_w16 = 1'b0;
    fast_mode = 1'b0; dly_en = 1'b0; early_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(strb() === 4'hF, "R1 reset strobes high", int'(strb()), 15);
    chk(busy === 1'b0 && done === 1'b0, "R9 reset busy/done low", int'(busy), 0);
    chk(req_ready === 1'b1, "R10 reset ready", int'(req_ready), 1);
    rst_n = 1'b1;
    for (int c = 0; c < 32; c++) begin
      for (int ti = 0; ti < 11; ti++) begin
        int t = (ti == 10) ? 99 : ti;
        run_cycle(c[0], c[1], c[2], c[3], c[4], t, ti == 3);
      end
    end
    back_to_back();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait (cyc >= 150000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule